// File: doc/BRIEF.md
# SEC-DED Memory Word Codec

This block guards an 8-bit memory word with a Hamming code that corrects any single flipped bit and detects any two flipped bits. On the write side it turns 8 data bits into a 13-bit stored word. That word holds the 8 data bits, 4 check bits, and one overall parity bit that gives the whole word even parity. On the read side it accepts a 13-bit word fetched from storage, repairs a single data-bit error, and reports what it found.

The two paths work independently, and both have registered outputs with one cycle of latency. A write request on `wr_valid` produces `enc_valid` with the stored word on the next cycle. A read request on `rd_valid` produces `dec_valid` with the corrected data and three flags on the next cycle.

The decoder sorts every read word into one of four error kinds:

- `ERR_NONE`: a clean word.
- `ERR_DATA`: one data bit flipped and was corrected.
- `ERR_CHECK`: one check bit or the parity bit flipped, so the data is untouched.
- `ERR_DOUBLE`: the error cannot be corrected.

A `unique case` on this kind sets the output flags.

Top module: `secded_codec`

## Requirements
- R1: Stored-word bit index i holds code position i+1. Check bits sit at positions 1, 2, 4 and 8 (bits 0, 1, 3, 7). Data bits D1..D8 sit at positions 3, 5, 6, 7, 9, 10, 11, 12 (bits 2, 4, 5, 6, 8, 9, 10, 11). With `wr_data[0]` = D1, the check bits are P1 = D1^D2^D4^D5^D7, P2 = D1^D3^D4^D6^D7, P4 = D2^D3^D4^D8 and P8 = D5^D6^D7^D8.
- R2: Bit 12 of the stored word is the XOR of bits 11..0, so every encoded 13-bit word has even parity.
- R3: `enc_valid` is high exactly one cycle after `wr_valid`, with `enc_word` holding the encoding of the data presented. The write path ignores the read path.
- R4: A read word with no flipped bit returns its data with `single_err`, `check_err` and `double_err` all 0.
- R5: A read word with exactly one flipped data bit returns the original data with `single_err`=1, `check_err`=0 and `double_err`=0.
- R6: A read word with exactly one flipped check bit returns the stored data unchanged with `single_err`=1, `check_err`=1 and `double_err`=0.
- R7: A read word where only the parity bit (bit 12) flipped returns the data unchanged with `single_err`=1, `check_err`=1 and `double_err`=0.
- R8: A read word with two flipped bits sets `double_err`=1 and clears the other flags. It returns the data bits as read, with no correction.
- R9: When the syndrome is 13, 14 or 15 and overall parity is odd, the decoder sets `double_err`=1, clears the other flags and applies no correction. An example is flips at positions 1, 2 and 12.
- R10: `dec_valid` is high exactly one cycle after `rd_valid`. The decode outputs and flags hold their values on cycles without `rd_valid`, whatever `rd_word` carries.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Encode request |
| wr_data | input | 8 | Data to encode, bit 0 = D1 |
| rd_valid | input | 1 | Decode request |
| rd_word | input | 13 | Stored word read back |
| enc_valid | output | 1 | Encoded word valid |
| enc_word | output | 13 | Encoded word to store |
| dec_valid | output | 1 | Decode result valid |
| dec_data | output | 8 | Corrected data |
| single_err | output | 1 | A single error was found and handled |
| check_err | output | 1 | The single error was in a check or parity bit |
| double_err | output | 1 | Uncorrectable error found |

## Verification
An encode and a decode can fall in the same cycle, because both register stages load on the same edge from separate inputs. The bench provokes this with random cycles that raise `wr_valid` and `rd_valid` together, each carrying different data and a random flip mask. In those cycles it judges both results against its own models: the encoded word against the written equations, and the decode data and flags against the expectation derived from the injected flip mask.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;

    // smallest K with 2^K - 1 >= M + K
    function automatic int chk_bits_for(input int m);
        int k;
        k = 1;
        while (((1 << k) - 1) < (m + k)) k++;
        return k;
    endfunction

    localparam int CHK_W  = chk_bits_for(DATA_W);
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int WORD_W = CODE_W + 1;
    localparam int PAR_IDX = CODE_W;

    typedef enum logic [1:0] {
        ERR_NONE,
        ERR_DATA,
        ERR_CHECK,
        ERR_DOUBLE
    } err_kind_e;

    function automatic bit is_pow2(input int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // code position (1-based) of data bit idx (0-based)
    function automatic int data_pos(input int idx);
        int seen;
        int r;
        seen = 0;
        r = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (seen == idx) r = p;
                seen++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);

    logic [CODE_W-1:0] code;
    logic [CHK_W-1:0]  chk;

    always_comb begin
        chk = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if ((data_pos(i) & (1 << k)) != 0) chk[k] = chk[k] ^ data_i[i];
            end
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < DATA_W; i++) code[data_pos(i) - 1] = data_i[i];
        for (int k = 0; k < CHK_W; k++) code[(1 << k) - 1] = chk[k];
    end

    assign word_o = {^code, code};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output err_kind_e         kind_o
);

    logic [DATA_W-1:0] raw;
    logic [CHK_W-1:0]  stored_chk;
    logic [CHK_W-1:0]  fresh_chk;
    logic [CHK_W-1:0]  syn;
    logic              par_odd;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) raw[i] = word_i[data_pos(i) - 1];
        for (int k = 0; k < CHK_W; k++) stored_chk[k] = word_i[(1 << k) - 1];
    end

    always_comb begin
        fresh_chk = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if ((data_pos(i) & (1 << k)) != 0) fresh_chk[k] = fresh_chk[k] ^ raw[i];
            end
        end
    end

    assign syn     = stored_chk ^ fresh_chk;
    assign par_odd = ^word_i;

    always_comb begin
        if (syn == '0)
            kind_o = par_odd ? ERR_CHECK : ERR_NONE;
        else if (!par_odd)
            kind_o = ERR_DOUBLE;
        else if (int'(syn) > CODE_W)
            kind_o = ERR_DOUBLE;
        else if (is_pow2(int'(syn)))
            kind_o = ERR_CHECK;
        else
            kind_o = ERR_DATA;
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            data_o[i] = raw[i] ^ ((kind_o == ERR_DATA) && (int'(syn) == data_pos(i)));
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_word,
    output logic              enc_valid,
    output logic [WORD_W-1:0] enc_word,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic              single_err,
    output logic              check_err,
    output logic              double_err
);

    logic [WORD_W-1:0] enc_c;
    logic [DATA_W-1:0] fix_c;
    err_kind_e         kind_c;
    logic              n_single, n_check, n_double;

    secded_enc u_enc (.data_i(wr_data), .word_o(enc_c));
    secded_dec u_dec (.word_i(rd_word), .data_o(fix_c), .kind_o(kind_c));

    always_comb begin
        unique case (kind_c)
            ERR_NONE:   begin n_single = 1'b0; n_check = 1'b0; n_double = 1'b0; end
            ERR_DATA:   begin n_single = 1'b1; n_check = 1'b0; n_double = 1'b0; end
            ERR_CHECK:  begin n_single = 1'b1; n_check = 1'b1; n_double = 1'b0; end
            ERR_DOUBLE: begin n_single = 1'b0; n_check = 1'b0; n_double = 1'b1; end
            default:    begin n_single = 1'b0; n_check = 1'b0; n_double = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid  <= 1'b0;
            enc_word   <= '0;
            dec_valid  <= 1'b0;
            dec_data   <= '0;
            single_err <= 1'b0;
            check_err  <= 1'b0;
            double_err <= 1'b0;
        end else begin
            enc_valid <= wr_valid;
            dec_valid <= rd_valid;
            if (wr_valid) enc_word <= enc_c;
            if (rd_valid) begin
                dec_data   <= fix_c;
                single_err <= n_single;
                check_err  <= n_check;
                double_err <= n_double;
            end
        end
    end

    p_enc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> (^enc_word) == 1'b0);

    p_enc_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> enc_valid);

    p_enc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !enc_valid);

    p_dec_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> dec_valid);

    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ($stable(dec_data) && $stable(single_err)
                       && $stable(check_err) && $stable(double_err)));

    p_double_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        double_err |-> (!single_err && !check_err));

    p_check_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        check_err |-> single_err);

endmodule

// File: tb/tb_secded_codec.sv
module tb_secded_codec;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [12:0] rd_word = '0;
    logic        enc_valid, dec_valid, single_err, check_err, double_err;
    logic [12:0] enc_word;
    logic [7:0]  dec_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_codec dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_word(rd_word),
        .enc_valid(enc_valid), .enc_word(enc_word),
        .dec_valid(dec_valid), .dec_data(dec_data),
        .single_err(single_err), .check_err(check_err), .double_err(double_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected <= %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1/R2 model from the written equations
    function automatic logic [12:0] m_enc(input logic [7:0] d);
        logic [12:0] w;
        w = '0;
        w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        w[2]  = d[0];
        w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
        w[4]  = d[1];
        w[5]  = d[2];
        w[6]  = d[3];
        w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
        w[8]  = d[4];
        w[9]  = d[5];
        w[10] = d[6];
        w[11] = d[7];
        w[12] = ^w[11:0];
        return w;
    endfunction

    function automatic logic [7:0] m_raw(input logic [12:0] w);
        return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
    endfunction

    function automatic bit is_data_idx(input int b);
        return (b == 2) || (b == 4) || (b == 5) || (b == 6) || (b >= 8 && b <= 11);
    endfunction

    // expected decode result from the flip mask (0..2 flips)
    task automatic expect_mask(input logic [7:0] d, input logic [12:0] mask,
                               output logic [7:0] ed, output logic [2:0] ef, output string req);
        int n;
        int b;
        n = $countones(mask);
        b = 0;
        for (int i = 0; i < 13; i++) if (mask[i]) b = i;
        if (n == 0) begin
            ed = d; ef = 3'b000; req = "R4";
        end else if (n == 1) begin
            ed = d;
            if (is_data_idx(b))      begin ef = 3'b100; req = "R5"; end
            else if (b == 12)        begin ef = 3'b110; req = "R7"; end
            else                     begin ef = 3'b110; req = "R6"; end
        end else begin
            ed = m_raw(m_enc(d) ^ mask); ef = 3'b001; req = "R8";
        end
    endtask

    // one cycle of stimulus, then the result is sampled at the following negedge
    task automatic cycle(input bit wv, input logic [7:0] wd, input bit rv, input logic [12:0] rw);
        wr_valid = wv; wr_data = wd; rd_valid = rv; rd_word = rw;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
    endtask

    task automatic check_read(input string req, input logic [7:0] ed, input logic [2:0] ef);
        check({req, " dec_valid"}, 32'(dec_valid), 32'd1);
        check({req, " dec_data"}, 32'(dec_data), 32'(ed));
        check({req, " flags{single,check,double}"},
              32'({single_err, check_err, double_err}), 32'(ef));
    endtask

    task automatic read_mask(input logic [7:0] d, input logic [12:0] mask);
        logic [7:0] ed;
        logic [2:0] ef;
        string req;
        expect_mask(d, mask, ed, ef, req);
        cycle(1'b0, 8'h00, 1'b1, m_enc(d) ^ mask);
        check_read(req, ed, ef);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs",
              32'({enc_valid, enc_word, dec_valid, dec_data, single_err, check_err, double_err}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 directed encodes
        cycle(1'b1, 8'b1101_0001, 1'b0, '0);
        check("R3 enc_valid", 32'(enc_valid), 32'd1);
        check("R1 enc_word 0xD1", 32'(enc_word), 32'(m_enc(8'hD1)));
        check("R2 even parity", 32'(^enc_word), 32'd0);
        cycle(1'b0, 8'h00, 1'b0, '0);
        check("R3 enc_valid drops", 32'(enc_valid), 32'd0);
        cycle(1'b1, 8'hFF, 1'b0, '0);
        check("R1 enc_word 0xFF", 32'(enc_word), 32'(m_enc(8'hFF)));

        // R4..R8 directed reads
        read_mask(8'hA5, 13'h0000);                 // R4 clean
        read_mask(8'hA5, 13'h0004);                 // R5 D1 flipped
        read_mask(8'h3C, 13'h0800);                 // R5 D8 flipped
        read_mask(8'h3C, 13'h0080);                 // R6 check bit pos 8
        read_mask(8'h3C, 13'h0001);                 // R6 check bit pos 1
        read_mask(8'h5A, 13'h1000);                 // R7 parity only
        read_mask(8'h5A, 13'h0204);                 // R8 two data bits
        read_mask(8'h5A, 13'h1008);                 // R8 parity + check

        // R9 syndrome 13/14/15 with odd parity
        cycle(1'b0, 8'h00, 1'b1, m_enc(8'h96) ^ 13'h0089);  // pos 1,4,8 -> 13
        check_read("R9 syn13", 8'h96, 3'b001);
        cycle(1'b0, 8'h00, 1'b1, m_enc(8'h96) ^ 13'h008A);  // pos 2,4,8 -> 14
        check_read("R9 syn14", 8'h96, 3'b001);
        cycle(1'b0, 8'h00, 1'b1, m_enc(8'h96) ^ 13'h0803);  // pos 1,2,12 -> 15
        check_read("R9 syn15 no correction", 8'h16, 3'b001);

        // R10 hold with rd_valid low and garbage on rd_word
        cycle(1'b0, 8'h00, 1'b0, 13'h1ABC);
        check("R10 dec_valid low", 32'(dec_valid), 32'd0);
        check("R10 hold data/flags",
              32'({dec_data, single_err, check_err, double_err}), 32'({8'h16, 3'b001}));

        // random mix, encodes and decodes often in the same cycle
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  d, wd;
            logic [12:0] mask;
            logic [7:0]  ed;
            logic [2:0]  ef;
            string       req;
            int          nf, p1, p2;
            bit          wv, rv;
            d  = 8'($urandom);
            wd = 8'($urandom);
            nf = $urandom % 3;
            p1 = $urandom % 13;
            p2 = (p1 + 1 + ($urandom % 12)) % 13;
            mask = '0;
            if (nf >= 1) mask[p1] = 1'b1;
            if (nf == 2) mask[p2] = 1'b1;
            wv = ($urandom % 4) != 0;
            rv = ($urandom % 4) != 0;
            expect_mask(d, mask, ed, ef, req);
            cycle(wv, wd, rv, m_enc(d) ^ mask);
            check("R3 random enc_valid", 32'(enc_valid), 32'(wv));
            if (wv) check("R1 random enc_word", 32'(enc_word), 32'(m_enc(wd)));
            if (rv) check_read({req, " random"}, ed, ef);
            else    check("R10 random dec_valid low", 32'(dec_valid), 32'd0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule